// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous burst static RAM with a word-addressed core of 32-bit words split into four 8-bit byte lanes. Address, write data, chip enables, write enables and burst controls are all taken on the rising clock edge. Read data is not re-registered: once an address has been registered, the addressed word appears on the output during the following cycle, gated by an asynchronous output enable. A valid flag marks when the output carries data; otherwise the output is driven to zero.

A new external address can be loaded through either of two address-status strobes. The processor strobe takes priority. It always performs a read, and it only acts when the primary chip enable is low. The controller strobe loads an address when the processor strobe does not, and a write on that load is decided by the write enables of the same cycle. The chip enables are sampled only on a load, and an inactive enable puts the device into a deselected state. Between loads, an advance input steps a two-bit burst counter through either a linear or an interleaved sequence inside an aligned group of four words, or holds the address as a wait state.

The core depth is the parameter `ADDR_W`. Its default is kept small so that the model elaborates quickly. A full 64K-word core is `ADDR_W = 16`.

Top module: `fts_burst_sram`

## Requirements
- R1: After reset the device is deselected: `rvalid_o` is 0 and `rdata_o` is 0.
- R2: A processor load (`ads_proc_n_i` = 0 and `ce_n_i` = 0) registers `addr_i` and resets the burst count. It writes nothing at that edge, whatever the write enables and `ads_ctrl_n_i` are.
- R3: When `ce_n_i` is 1 the processor strobe is ignored. With `ads_ctrl_n_i` also at 1 and `adv_n_i` at 1, the registered address and the selection state do not change.
- R4: A controller load (`ads_ctrl_n_i` = 0 with no processor load) registers `addr_i`. If all chip enables are active, the write enables of that same cycle write `wdata_i` to `addr_i`.
- R5: Chip enables are ignored on edges with no load. Changing them during a burst does not alter selection, reads or writes.
- R6: A load with `ce_n_i` = 1, `ce2_i` = 0 or `ce2_n_i` = 1 deselects the device. While deselected, `rvalid_o` is 0 and no word is written until a load with all three enables active.
- R7: `gw_n_i` = 0 on a write edge writes all four lanes, whatever `bw_en_n_i` and `lane_n_i` are.
- R8: With `gw_n_i` = 1, lane k (bits 8k+7..8k) is written only when `bw_en_n_i` = 0 and `lane_n_i[k]` = 0.
- R9: On a selected edge with no load, `adv_n_i` = 0 steps the burst count by one. `adv_n_i` = 1 holds the address (wait state).
- R10: Address bits above bit 1 stay fixed during a burst. The low two bits are `(base + count) mod 4` when `burst_lin_i` = 1 and `base XOR count` when `burst_lin_i` = 0.
- R11: A write on an edge with no load goes to the address registered at that edge, after any advance. With `adv_n_i` = 1 on the first edge after a processor load, the write lands on the loaded address.
- R12: In the cycle after an edge, while selected and enabled, `rdata_o` shows the word at the registered address, including a write made at that same edge.
- R13: `oe_n_i` acts combinationally: `rvalid_o` equals (selected AND NOT `oe_n_i`), and `rdata_o` is 0 whenever `rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all synchronous inputs taken on rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| ce_n_i | input | 1 | Primary chip enable, active low; also qualifies processor strobe |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce2_n_i | input | 1 | Secondary chip enable, active low |
| ads_proc_n_i | input | 1 | Processor address strobe, active low |
| ads_ctrl_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Global write, active low |
| bw_en_n_i | input | 1 | Byte-write enable, active low |
| lane_n_i | input | 4 | Per-lane write enables, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| burst_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata_o | output | 32 | Read data, zero when not valid |
| rvalid_o | output | 1 | Output carries valid read data |

## Verification
The key collision is a load and a write on the same edge. When the processor and controller strobes are both low while global write or byte writes are active, the processor strobe must win and force a read. When the controller strobe alone loads, the write of that same edge must land on the new address. The bench provokes these cases, and also a load with an inactive secondary enable that carries an active global write. It judges them with a per-clock behavioural model that keeps a lane-masked reference memory and the expected burst address. Every read, before and after these edges, is compared against that model.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int LANE_W  = 8;
  localparam int N_LANES = 4;
  localparam int DATA_W  = LANE_W * N_LANES;
  localparam int CNT_W   = 2;

  typedef enum logic {
    ORDER_INTLV = 1'b0,
    ORDER_LIN   = 1'b1
  } burst_order_e;

  function automatic logic [CNT_W-1:0] burst_low(input logic [CNT_W-1:0] base,
                                                 input logic [CNT_W-1:0] cnt,
                                                 input burst_order_e     ord);
    return (ord == ORDER_LIN) ? CNT_W'(base + cnt) : (base ^ cnt);
  endfunction
endpackage

// File: rtl/fts_burst_addr.sv
module fts_burst_addr
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] base_q, base_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  burst_order_e      ord;

  assign ord = lin_i ? ORDER_LIN : ORDER_INTLV;

  always_comb begin
    base_n = base_q;
    cnt_n  = cnt_q;
    if (load_i) begin
      base_n = addr_i;
      cnt_n  = '0;
    end else if (adv_i) begin
      cnt_n  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end

  assign cur_addr_o = {base_q[ADDR_W-1 -: HI_W], burst_low(base_q[CNT_W-1:0], cnt_q, ord)};
  assign nxt_addr_o = {base_n[ADDR_W-1 -: HI_W], burst_low(base_n[CNT_W-1:0], cnt_n, ord)};

  // R9
  hold_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> (cnt_q == $past(cnt_q)));

  // R9
  step_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));

  // R10
  high_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cur_addr_o[ADDR_W-1:CNT_W] == $past(cur_addr_o[ADDR_W-1:CNT_W])));
endmodule

// File: rtl/fts_cycle_ctrl.sv
module fts_cycle_ctrl
  import fts_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_n_i,
  input  logic               ce2_i,
  input  logic               ce2_n_i,
  input  logic               ads_proc_n_i,
  input  logic               ads_ctrl_n_i,
  input  logic               adv_n_i,
  input  logic               gw_n_i,
  input  logic               bw_en_n_i,
  input  logic [N_LANES-1:0] lane_n_i,
  input  logic               oe_n_i,
  output logic               load_o,
  output logic               adv_o,
  output logic [N_LANES-1:0] we_o,
  output logic               rvalid_o
);
  logic load_proc, load_ctrl, en_all, wr_ok;
  logic sel_q;
  logic [N_LANES-1:0] mask;

  assign load_proc = !ads_proc_n_i && !ce_n_i;
  assign load_ctrl = !load_proc && !ads_ctrl_n_i;
  assign load_o    = load_proc || load_ctrl;
  assign en_all    = !ce_n_i && ce2_i && !ce2_n_i;
  assign adv_o     = !load_o && sel_q && !adv_n_i;

  always_comb begin
    if (!gw_n_i)         mask = '1;
    else if (!bw_en_n_i) mask = ~lane_n_i;
    else                 mask = '0;
  end

  // processor load reads; controller load writes only when newly selected
  assign wr_ok = !load_proc && (load_ctrl ? en_all : sel_q);
  assign we_o  = wr_ok ? mask : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= 1'b0;
    else if (load_o) sel_q <= en_all;
  end

  assign rvalid_o = sel_q && !oe_n_i;

  // R13
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !rvalid_o);

  // R6
  desel_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_q && !load_o) |-> (we_o == '0));

  // R7
  global_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gw_n_i && (we_o != '0)) |-> (we_o == '1));

  // R5
  ce_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> (sel_q == $past(sel_q)));
endmodule

// File: rtl/fts_byte_core.sv
module fts_byte_core
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic               clk_i,
  input  logic [N_LANES-1:0] we_i,
  input  logic [ADDR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              ce_n_i,
  input  logic              ce2_i,
  input  logic              ce2_n_i,
  input  logic              ads_proc_n_i,
  input  logic              ads_ctrl_n_i,
  input  logic              adv_n_i,
  input  logic              gw_n_i,
  input  logic              bw_en_n_i,
  input  logic [3:0]        lane_n_i,
  input  logic              oe_n_i,
  input  logic              burst_lin_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o
);
  logic               load, adv, valid;
  logic [N_LANES-1:0] we;
  logic [ADDR_W-1:0]  cur_addr, nxt_addr;
  logic [DATA_W-1:0]  core_rdata;

  fts_cycle_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_n_i       (ce_n_i),
    .ce2_i        (ce2_i),
    .ce2_n_i      (ce2_n_i),
    .ads_proc_n_i (ads_proc_n_i),
    .ads_ctrl_n_i (ads_ctrl_n_i),
    .adv_n_i      (adv_n_i),
    .gw_n_i       (gw_n_i),
    .bw_en_n_i    (bw_en_n_i),
    .lane_n_i     (lane_n_i),
    .oe_n_i       (oe_n_i),
    .load_o       (load),
    .adv_o        (adv),
    .we_o         (we),
    .rvalid_o     (valid)
  );

  fts_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .adv_i      (adv),
    .lin_i      (burst_lin_i),
    .addr_i     (addr_i),
    .cur_addr_o (cur_addr),
    .nxt_addr_o (nxt_addr)
  );

  fts_byte_core #(.ADDR_W(ADDR_W)) u_core (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (nxt_addr),
    .wdata_i (wdata_i),
    .raddr_i (cur_addr),
    .rdata_o (core_rdata)
  );

  assign rvalid_o = valid;
  assign rdata_o  = valid ? core_rdata : '0;

  // R2
  proc_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_n_i && !ce_n_i) |-> (we == '0));

  // R3
  proc_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_proc_n_i && ce_n_i && ads_ctrl_n_i && adv_n_i)
      |=> ((burst_lin_i != $past(burst_lin_i)) || (cur_addr == $past(cur_addr))));

  // R4
  ctrl_load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ads_proc_n_i || ce_n_i) && !ads_ctrl_n_i) |=> (cur_addr == $past(addr_i)));

  // R13
  zero_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));
endmodule

// File: tb/fts_burst_sram_tb.sv
`timescale 1ns/1ps
module fts_burst_sram_tb_top;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          ce_n = 1'b0, ce2 = 1'b1, ce2_n = 1'b0;
  logic          ap_n = 1'b1, ac_n = 1'b1, adv_n = 1'b1;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    lane_n = 4'hf;
  logic          oe_n = 1'b0;
  logic          lin = 1'b1;
  logic [31:0]   rdata;
  logic          rvalid;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0]   ref_mem [DEPTH];
  logic [3:0]    ref_kn  [DEPTH];
  logic [AW-1:0] ref_base = '0;
  logic [1:0]    ref_cnt = '0;
  bit            ref_sel = 1'b0;

  always #2.5 clk = ~clk;

  fts_burst_sram #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .ce_n_i(ce_n), .ce2_i(ce2), .ce2_n_i(ce2_n),
    .ads_proc_n_i(ap_n), .ads_ctrl_n_i(ac_n), .adv_n_i(adv_n),
    .gw_n_i(gw_n), .bw_en_n_i(bwe_n), .lane_n_i(lane_n), .oe_n_i(oe_n),
    .burst_lin_i(lin), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic logic [AW-1:0] seq_addr(logic [AW-1:0] b, logic [1:0] c, logic l);
    logic [1:0] lo;
    lo = l ? 2'(b[1:0] + c) : (b[1:0] ^ c);
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference update at a rising edge, from the bench's own inputs
  task automatic ref_edge();
    bit lp, lc, en, wok;
    logic [AW-1:0] nb, wa;
    logic [1:0] nc;
    logic [3:0] m;
    bit ns;
    lp = !ap_n && !ce_n;
    lc = !lp && !ac_n;
    en = !ce_n && ce2 && !ce2_n;
    nb = ref_base; nc = ref_cnt; ns = ref_sel;
    if (lp || lc) begin nb = addr; nc = 2'd0; ns = en; end
    else if (ref_sel && !adv_n) nc = ref_cnt + 2'd1;
    wok = !lp && (lc ? en : ref_sel);
    m = !gw_n ? 4'hf : (!bwe_n ? ~lane_n : 4'h0);
    wa = seq_addr(nb, nc, lin);
    if (wok) for (int k = 0; k < 4; k++) if (m[k]) begin
      ref_mem[wa][k*8 +: 8] = wdata[k*8 +: 8];
      ref_kn[wa][k] = 1'b1;
    end
    ref_base = nb; ref_cnt = nc; ref_sel = ns;
  endtask

  task automatic compare(input string tag);
    bit ev;
    logic [AW-1:0] a;
    logic [31:0] km;
    ev = ref_sel && !oe_n;
    chk({tag, " valid"}, rvalid === ev, {31'd0, rvalid}, {31'd0, ev});
    if (ev) begin
      a = seq_addr(ref_base, ref_cnt, lin);
      km = {{8{ref_kn[a][3]}}, {8{ref_kn[a][2]}}, {8{ref_kn[a][1]}}, {8{ref_kn[a][0]}}};
      chk({tag, " data"}, ((rdata ^ ref_mem[a]) & km) == 32'd0, rdata & km, ref_mem[a] & km);
    end else begin
      chk({tag, " zero"}, rdata === 32'd0, rdata, 32'd0);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    ref_edge();
    @(negedge clk);
    compare(tag);
    ap_n = 1'b1; ac_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; lane_n = 4'hf;
  endtask

  task automatic ctrl_load(input logic [AW-1:0] a, input logic [31:0] d, input logic g,
                           input string tag);
    addr = a; wdata = d; ac_n = 1'b0; gw_n = g;
    step(tag);
  endtask

  task automatic cont(input logic av, input logic [31:0] d, input logic g, input logic b,
                      input logic [3:0] ln, input string tag);
    adv_n = av; wdata = d; gw_n = g; bwe_n = b; lane_n = ln;
    step(tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = '0; ref_kn[i] = 4'h0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    compare("R1 reset");
    step("R1 idle");

    // controller load with global write, then linear burst with byte writes
    lin = 1'b1;
    ctrl_load(10'h040, 32'h1111_1111, 1'b0, "R4 R7 R12 ctrl write");
    cont(1'b0, 32'h2222_2222, 1'b1, 1'b0, 4'b1100, "R8 R9 R10 lane write");
    cont(1'b0, 32'h3333_3333, 1'b0, 1'b0, 4'b1111, "R7 R9 gw overrides lanes");
    cont(1'b1, 32'h4444_4444, 1'b0, 1'b1, 4'hf, "R9 R11 wait write");
    cont(1'b0, 32'h5555_5555, 1'b0, 1'b1, 4'hf, "R10 R11 linear step");
    cont(1'b0, 32'h6666_6666, 1'b1, 1'b0, 4'b0101, "R8 R10 linear wrap");
    cont(1'b1, 32'h0, 1'b1, 1'b1, 4'hf, "R12 read back");

    // processor load with both strobes and writes active: read only
    lin = 1'b0;
    addr = 10'h042; wdata = 32'hDEAD_BEEF; ap_n = 1'b0; ac_n = 1'b0; gw_n = 1'b0;
    step("R2 proc beats ctrl and write");
    cont(1'b0, 32'h0, 1'b1, 1'b1, 4'hf, "R10 interleaved 1");
    cont(1'b0, 32'h0, 1'b1, 1'b1, 4'hf, "R10 interleaved 2");
    cont(1'b0, 32'h0, 1'b1, 1'b1, 4'hf, "R10 interleaved 3");
    cont(1'b0, 32'h0, 1'b1, 1'b1, 4'hf, "R10 interleaved wrap");

    // processor strobe ignored while primary enable high
    ce_n = 1'b1; addr = 10'h300; ap_n = 1'b0;
    step("R3 proc ignored");
    ce_n = 1'b0;
    cont(1'b1, 32'h0, 1'b1, 1'b1, 4'hf, "R3 address kept");

    // processor load then write with advance held high
    lin = 1'b1;
    addr = 10'h080; ap_n = 1'b0; bwe_n = 1'b0; lane_n = 4'h0;
    step("R2 proc load");
    cont(1'b1, 32'h7777_7777, 1'b0, 1'b1, 4'hf, "R11 first write at loaded addr");
    cont(1'b0, 32'h8888_8888, 1'b0, 1'b1, 4'hf, "R11 second write advanced");

    // enables changed mid-burst are ignored
    ce2 = 1'b0; ce2_n = 1'b1; ce_n = 1'b1;
    cont(1'b0, 32'h9999_9999, 1'b0, 1'b1, 4'hf, "R5 enables ignored write");
    cont(1'b0, 32'h0, 1'b1, 1'b1, 4'hf, "R5 enables ignored read");
    ce2 = 1'b1; ce2_n = 1'b0; ce_n = 1'b0;

    // deselecting loads
    ce2 = 1'b0;
    ctrl_load(10'h040, 32'hBAD0_0001, 1'b0, "R6 deselect ce2");
    ce2 = 1'b1;
    cont(1'b0, 32'hBAD0_0002, 1'b0, 1'b1, 4'hf, "R6 no write deselected");
    cont(1'b1, 32'hBAD0_0003, 1'b1, 1'b0, 4'h0, "R6 no byte write deselected");
    ctrl_load(10'h040, 32'h0, 1'b1, "R6 reselect read");
    cont(1'b0, 32'h0, 1'b1, 1'b1, 4'hf, "R6 memory intact");
    ce2_n = 1'b1;
    ctrl_load(10'h041, 32'hBAD0_0004, 1'b0, "R6 deselect ce2_n");
    ce2_n = 1'b0;
    ce_n = 1'b1; addr = 10'h041; ap_n = 1'b0; ac_n = 1'b0; gw_n = 1'b0; wdata = 32'hBAD0_0005;
    step("R3 R6 ctrl load with primary high");
    ce_n = 1'b0;
    ctrl_load(10'h041, 32'h0, 1'b1, "R6 reselect check");

    // asynchronous output enable within one cycle
    #1 oe_n = 1'b1;
    #0.5 chk("R13 oe off valid", rvalid === 1'b0, {31'd0, rvalid}, 32'd0);
    chk("R13 oe off zero", rdata === 32'd0, rdata, 32'd0);
    oe_n = 1'b0;
    #0.5 chk("R13 oe on valid", rvalid === 1'b1, {31'd0, rvalid}, 32'd1);
    @(negedge clk);
    compare("R13 oe restored");
    oe_n = 1'b1;
    cont(1'b0, 32'h0, 1'b1, 1'b1, 4'hf, "R13 oe held off");
    oe_n = 1'b0;
    cont(1'b1, 32'h0, 1'b1, 1'b1, 4'hf, "R12 R13 read after oe");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule